// File: doc/BRIEF.md
# Banked ROM Controller with Internal Nibble RAM

This block connects an 8-bit CPU bus to a cartridge ROM of up to 16 banks of 16 KiB. The CPU bus has a 16-bit address, 8-bit data, and read and write strobes. The lower CPU window at 0x0000–0x3FFF always shows bank 0. The upper window at 0x4000–0x7FFF shows whichever bank the CPU last selected. The block forms the 18-bit ROM address from the CPU address and the selected bank, and presents it one clock later.

Control writes land anywhere in 0x0000–0x3FFF. CPU address bit 8 decides which of two registers the write reaches: a RAM enable flag or the 4-bit bank number.

The block also holds 512 entries of 4-bit RAM. The CPU reaches this RAM through 0xA000–0xBFFF, and the RAM repeats every 512 bytes across that window. Read data comes back one cycle after the read strobe. The upper nibble of RAM read data is forced to ones so that the value is always defined.

Top module: `nibble_bank_ctrl`

## Requirements
- R1: When the registered CPU address has bits 15:14 other than 01, `rom_addr` equals {4'b0000, addr[13:0]}. This covers the fixed window at 0x0000–0x3FFF, which always shows bank 0.
- R2: When the registered CPU address lies in 0x4000–0x7FFF, `rom_addr` equals {bank, addr[13:0]}. `rom_addr` is registered and appears one clock after the address is presented.
- R3: A write to 0x0000–0x3FFF with address bit 8 = 0 sets RAM enable if the data is exactly 0x0A. Any other data value clears RAM enable.
- R4: A write to 0x0000–0x3FFF with address bit 8 = 1 loads data bits 3:0 into the bank register. A value of 0 is stored as bank 1, so the bank register never holds 0.
- R5: After reset, RAM is disabled and the bank register holds 1.
- R6: The RAM holds 512 four-bit entries and is indexed by address bits 8:0. Every 512-byte slice of 0xA000–0xBFFF reaches the same entries. A write stores data bits 3:0 only.
- R7: An enabled read in 0xA000–0xBFFF returns {4'b1111, entry} on `ram_rdata` in the cycle after the read strobe.
- R8: While RAM is disabled, writes to 0xA000–0xBFFF leave the RAM unchanged, and reads there return 0xFF.
- R9: Writes to 0x4000–0x7FFF change neither the bank register nor RAM enable.
- R10: In any cycle that does not follow an enabled RAM read, `ram_rdata` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one write per clock |
| cpu_rd | input | 1 | Read strobe |
| rom_addr | output | 18 | Registered external ROM address |
| ram_rdata | output | 8 | Registered internal RAM read data |

## Verification
The bench goes after the written value 0, which must become bank 1. A design that stores it raw would point the upper window at bank 0, and `rom_addr[17:14]` would read 0000 where 0001 is expected. It also sweeps control addresses with bit 8 both set and clear, and writes values close to 0x0A. A decoder that looks at the wrong address bit, or compares only part of the data, either enables the RAM by mistake or changes the wrong register.

RAM accesses use addresses scattered across all mirrors of the window, so a design that indexes with too few or the wrong address bits returns stale nibbles. Writes made while RAM is disabled, and writes into the upper ROM window, are each followed by reads back through the ports. Those reads expose any leak into the RAM, the enable flag or the bank register.

// File: rtl/nbc_pkg.sv
package nbc_pkg;
  localparam int CPU_AW = 16;
  localparam int CPU_DW = 8;

  typedef enum logic [1:0] {
    RGN_CTRL   = 2'd0,
    RGN_BANKED = 2'd1,
    RGN_RAM    = 2'd2,
    RGN_OTHER  = 2'd3
  } region_e;

  function automatic region_e region_of(input logic [CPU_AW-1:0] a);
    if (a[15:14] == 2'b00)      return RGN_CTRL;
    else if (a[15:14] == 2'b01) return RGN_BANKED;
    else if (a[15:13] == 3'b101) return RGN_RAM;
    else                         return RGN_OTHER;
  endfunction
endpackage

// File: rtl/nbc_regs.sv
module nbc_regs #(
  parameter int          BANK_W     = 4,
  parameter int          DATA_W     = 8,
  parameter logic [7:0]  ENABLE_KEY = 8'h0A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic              sel_bank,
  input  logic [DATA_W-1:0] wdata,
  output logic              ram_en,
  output logic [BANK_W-1:0] bank
);
  localparam logic [BANK_W-1:0] BANK_ONE = BANK_W'(1);

  logic [BANK_W-1:0] wbank;
  assign wbank = wdata[BANK_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_en <= 1'b0;
      bank   <= BANK_ONE;
    end else if (ctrl_wr) begin
      if (sel_bank) bank   <= (wbank == '0) ? BANK_ONE : wbank;
      else          ram_en <= (wdata == ENABLE_KEY);
    end
  end

  // R4
  bank_never_zero_chk: assert property (@(posedge clk) disable iff (rst)
    bank != '0);
  // R5
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bank == BANK_ONE && !ram_en));
  // R3
  enable_key_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !sel_bank) |=> (ram_en == ($past(wdata) == ENABLE_KEY)));
  // R9
  regs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_wr |=> ($stable(bank) && $stable(ram_en)));
endmodule

// File: rtl/nbc_rom_map.sv
module nbc_rom_map #(
  parameter int BANK_W = 4,
  parameter int WIN_W  = 14,
  parameter int AW     = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [AW-1:0]           addr,
  input  logic [BANK_W-1:0]       bank,
  output logic [BANK_W+WIN_W-1:0] rom_addr
);
  logic banked;
  assign banked = (addr[AW-1:WIN_W] == 2'b01);

  always_ff @(posedge clk) begin
    if (rst) rom_addr <= '0;
    else     rom_addr <= {(banked ? bank : BANK_W'(0)), addr[WIN_W-1:0]};
  end

  // R1
  fixed_window_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(addr[AW-1:WIN_W]) != 2'b01) |->
      rom_addr[BANK_W+WIN_W-1:WIN_W] == '0);
  // R2
  window_offset_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rom_addr[WIN_W-1:0] == $past(addr[WIN_W-1:0]));
endmodule

// File: rtl/nbc_nibble_ram.sv
module nbc_nibble_ram #(
  parameter int IDX_W  = 9,
  parameter int NIB_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic              rd_hit,
  input  logic              ram_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [NIB_W-1:0]  wnib,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [DATA_W-NIB_W-1:0] PAD = '1;

  logic [NIB_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_hit && ram_en) mem[idx] <= wnib;
  end

  always_ff @(posedge clk) begin
    if (rst)                    rdata <= '1;
    else if (rd_hit && ram_en)  rdata <= {PAD, mem[idx]};
    else                        rdata <= '1;
  end

  // R10
  idle_ff_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_hit && ram_en) |=> rdata == '1);
  // R7
  upper_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && ram_en) |=> rdata[DATA_W-1:NIB_W] == PAD);
endmodule

// File: rtl/nibble_bank_ctrl.sv
module nibble_bank_ctrl
  import nbc_pkg::*;
#(
  parameter int          BANK_W     = 4,
  parameter int          WIN_W      = 14,
  parameter int          IDX_W      = 9,
  parameter int          NIB_W      = 4,
  parameter int          SEL_BIT    = 8,
  parameter logic [7:0]  ENABLE_KEY = 8'h0A
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CPU_AW-1:0]       cpu_addr,
  input  logic [CPU_DW-1:0]       cpu_wdata,
  input  logic                    cpu_wr,
  input  logic                    cpu_rd,
  output logic [BANK_W+WIN_W-1:0] rom_addr,
  output logic [CPU_DW-1:0]       ram_rdata
);
  region_e          rgn;
  logic             ram_en;
  logic [BANK_W-1:0] bank;

  assign rgn = region_of(cpu_addr);

  nbc_regs #(.BANK_W(BANK_W), .DATA_W(CPU_DW), .ENABLE_KEY(ENABLE_KEY)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .ctrl_wr  (cpu_wr && rgn == RGN_CTRL),
    .sel_bank (cpu_addr[SEL_BIT]),
    .wdata    (cpu_wdata),
    .ram_en   (ram_en),
    .bank     (bank)
  );

  nbc_rom_map #(.BANK_W(BANK_W), .WIN_W(WIN_W), .AW(CPU_AW)) u_map (
    .clk      (clk),
    .rst      (rst),
    .addr     (cpu_addr),
    .bank     (bank),
    .rom_addr (rom_addr)
  );

  nbc_nibble_ram #(.IDX_W(IDX_W), .NIB_W(NIB_W), .DATA_W(CPU_DW)) u_ram (
    .clk    (clk),
    .rst    (rst),
    .wr_hit (cpu_wr && rgn == RGN_RAM),
    .rd_hit (cpu_rd && rgn == RGN_RAM),
    .ram_en (ram_en),
    .idx    (cpu_addr[IDX_W-1:0]),
    .wnib   (cpu_wdata[NIB_W-1:0]),
    .rdata  (ram_rdata)
  );

  // R8
  disabled_read_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && rgn == RGN_RAM && !ram_en) |=> ram_rdata == 8'hFF);
endmodule

// File: tb/nibble_bank_ctrl_test.sv
module nibble_bank_ctrl_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_wr, cpu_rd;
  logic [17:0] rom_addr;
  logic [7:0]  ram_rdata;

  int checks = 0;
  int errors = 0;

  logic       m_en;
  logic [3:0] m_bank;
  logic [3:0] m_mem [512];

  always #2.5 clk = ~clk;

  nibble_bank_ctrl uut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .rom_addr(rom_addr), .ram_rdata(ram_rdata)
  );

  function automatic logic [17:0] exp_rom(input logic [15:0] a, input logic [3:0] b);
    return {(a[15:14] == 2'b01) ? b : 4'h0, a[13:0]};
  endfunction

  function automatic logic [3:0] exp_bank(input logic [7:0] d);
    return (d[3:0] == 4'h0) ? 4'h1 : d[3:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [15:0] a, input logic [7:0] d, input logic w, input logic r);
    cpu_addr = a; cpu_wdata = d; cpu_wr = w; cpu_rd = r;
    @(posedge clk);
    @(negedge clk);
    cpu_wr = 1'b0; cpu_rd = 1'b0;
  endtask

  task automatic reg_wr(input logic [15:0] a, input logic [7:0] d);
    cyc(a, d, 1'b1, 1'b0);
    if (a[15:14] == 2'b00) begin
      if (a[8]) m_bank = exp_bank(d);
      else      m_en = (d == 8'h0A);
    end
  endtask

  task automatic rom_chk(input string req, input logic [15:0] a);
    cyc(a, 8'h00, 1'b0, 1'b0);
    check(req, 32'(rom_addr), 32'(exp_rom(a, m_bank)));
  endtask

  task automatic ram_wr(input logic [15:0] a, input logic [7:0] d);
    cyc(a, d, 1'b1, 1'b0);
    if (m_en) m_mem[a[8:0]] = d[3:0];
  endtask

  task automatic ram_chk(input string req, input logic [15:0] a);
    cyc(a, 8'h00, 1'b0, 1'b1);
    check(req, 32'(ram_rdata), 32'(m_en ? {4'hF, m_mem[a[8:0]]} : 8'hFF));
  endtask

  function automatic logic [15:0] ram_addr(input logic [8:0] i);
    return {3'b101, 4'($urandom_range(0, 15)), i};
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7731));
    cpu_addr = '0; cpu_wdata = '0; cpu_wr = 0; cpu_rd = 0;
    rst = 1'b1;
    m_en = 0; m_bank = 4'h1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R5 reset state: bank 1 visible, RAM reads FF
    rom_chk("R5", 16'h4123);
    check("R5", 32'(rom_addr[17:14]), 32'h1);
    ram_chk("R5", 16'hA010);
    // R10 idle output
    cyc(16'h1234, 8'h00, 1'b0, 1'b0);
    check("R10", 32'(ram_rdata), 32'hFF);

    // R1 fixed window
    rom_chk("R1", 16'h3FFF);
    rom_chk("R1", 16'h0000);

    // R4 zero becomes bank 1; full-range bank
    reg_wr(16'h2100, 8'hF0);
    rom_chk("R4", 16'h7FFF);
    reg_wr(16'h0100, 8'h3F);
    rom_chk("R4", 16'h4000);
    check("R4", 32'(rom_addr[17:14]), 32'hF);
    // bit 8 clear must not touch bank
    reg_wr(16'h3E00, 8'h05);
    rom_chk("R3", 16'h5555);

    // R3 enable and near-key values
    reg_wr(16'h0000, 8'h0A);
    ram_wr(16'hA003, 8'hE9);
    ram_chk("R3", 16'hA003);
    reg_wr(16'h00FF, 8'h1A);
    ram_chk("R3", 16'hA003);
    reg_wr(16'h3EFF, 8'h0A);
    // R6 mirror
    ram_wr(16'hA1FF, 8'h5C);
    ram_chk("R6", 16'hBFFF);
    ram_chk("R6", 16'hA003);

    // R9 writes in banked window ignored
    reg_wr(16'h4100, 8'h02);
    reg_wr(16'h4000, 8'h00);
    ram_chk("R9", 16'hB003);
    rom_chk("R9", 16'h6000);

    // R8 disabled writes dropped
    reg_wr(16'h0200, 8'h0B);
    ram_wr(16'hA003, 8'h01);
    ram_chk("R8", 16'hA003);
    reg_wr(16'h0400, 8'h0A);
    ram_chk("R8", 16'hA003);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int k;
      logic [15:0] a;
      logic [7:0]  d;
      k = $urandom_range(0, 5);
      d = 8'($urandom);
      case (k)
        0: begin
          a = {2'b00, 14'($urandom)};
          if ($urandom_range(0, 2) == 0) d = 8'h0A;
          reg_wr(a, d);
        end
        1: rom_chk("R2", 16'($urandom));
        2: ram_wr(ram_addr(9'($urandom)), d);
        3: ram_chk("R7", ram_addr(9'($urandom)));
        4: reg_wr({2'b01, 14'($urandom)}, d);
        default: begin
          cyc(16'($urandom) | 16'hC000, d, 1'b0, 1'b0);
          check("R10", 32'(ram_rdata), 32'hFF);
        end
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule